// File: doc/BRIEF.md
# Four-Phase Refresh-and-Access Storage Sequencer

This block owns a 1024-word by 36-bit storage array and keeps every word alive. It does this by running a four-phase cycle without pause. In each idle cycle it picks the word named by its regeneration counter, then reads that word and writes it back. A client reaches the array through a single-entry request channel. The sequencer takes one request at a time, holds its address and data, and waits for the start of the next phase-0 slot. It then uses one whole four-phase cycle for the read or the write, and afterwards goes back to regeneration without being told.

The request channel is valid/ready. `req_ready` is high only while no accepted request is outstanding. A transfer happens on a rising edge where `req_valid` and `req_ready` are both high. The client may hold `req_valid` high for as long as it likes, and nothing is taken while `req_ready` is low. Completion is a plain single-cycle `resume` pulse with no back-pressure. Read results appear on `rd_data` in the cycle where `resume` is high. Because accesses can only begin at phase 0, the time from acceptance to `resume` depends on the phase that is running when the request is taken.

Top module: `storage_refresh_seq`

## Requirements
- R1: After reset `phase` is 0. It then advances by one on every clock, 0, 1, 2, 3, and returns to 0.
- R2: After reset `regen_addr` is 0. Each regeneration cycle raises it by one at the end of its phase 0, so the value seen during phases 1 to 3 and during the following phase 0 is one greater. After 1023 it wraps to 0.
- R3: An access begins only in a phase-0 cycle that comes after the acceptance edge. Let p be the `phase` sampled in the accepting cycle and w = (4 - ((p+1) mod 4)) mod 4. Then `resume` is high in the (w+5)-th cycle after that cycle, and `phase` is 0 in that cycle.
- R4: After reset `req_ready` is 1. It is 0 from the cycle after an acceptance until `resume` is high. A request offered while `req_ready` is 0 does not change the array and does not start an access.
- R5: A write (`req_write`=1) stores `req_wdata` at `req_addr`.
- R6: A read (`req_write`=0) puts the word stored at `req_addr` on `rd_data` in the `resume` cycle and leaves that word unchanged.
- R7: `resume` is high for exactly one cycle per access. It is 0 out of reset.
- R8: `rd_data` is 0 out of reset and changes only when a read completes. A write leaves it unchanged.
- R9: `regen_addr` does not advance during the four-phase cycle used by an access.
- R10: Regeneration keeps stored words intact. A word read after more than a full sweep of the counter still equals the last value written to it.
- R11: After an access the sequencer regenerates again without any stimulus. `regen_addr` advances at the end of the `resume` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 10 | Word address |
| req_wdata | input | 36 | Write data |
| rd_data | output | 36 | Data of the last completed read |
| resume | output | 1 | Single-cycle access-complete pulse |
| phase | output | 2 | Current phase of the four-phase cycle |
| regen_addr | output | 10 | Regeneration counter |

## Verification
The embedded properties check several rules on every clock: the phase stepping, that `resume` is a one-cycle pulse landing on phase 0, that the latched address holds while the channel is busy, that the counter freezes during an access, and that `rd_data` moves only at a read's completion. Other behaviours can only be shown by the bench's scenarios. These are the exact phase-dependent latency, that data written survives reads and long regeneration sweeps, that requests offered while busy leave no trace, and that the counter wraps from 1023 to 0. The bench shows these by comparing the ports against a word-level model over random operations with random gaps.

// File: rtl/sseq_pkg.sv
package sseq_pkg;

  typedef enum logic [1:0] {
    MODE_REGEN = 2'd0,
    MODE_READ  = 2'd1,
    MODE_WRITE = 2'd2
  } sseq_mode_e;

  localparam int unsigned PHASE_W     = 2;
  localparam int unsigned PHASE_COUNT = 1 << PHASE_W;

  localparam logic [PHASE_W-1:0] PH_SELECT  = 2'd0;
  localparam logic [PHASE_W-1:0] PH_SETTLE  = 2'd1;
  localparam logic [PHASE_W-1:0] PH_SAMPLE  = 2'd2;
  localparam logic [PHASE_W-1:0] PH_FINISH  = 2'd3;

endpackage

// File: rtl/sseq_phase.sv
module sseq_phase
  import sseq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  output logic [PHASE_W-1:0] phase_o,
  output logic               at_select_o,
  output logic               at_sample_o,
  output logic               at_finish_o
);

  logic [PHASE_W-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n) phase_q <= PH_SELECT;
    else        phase_q <= phase_q + 1'b1;
  end

  assign phase_o     = phase_q;
  assign at_select_o = (phase_q == PH_SELECT);
  assign at_sample_o = (phase_q == PH_SAMPLE);
  assign at_finish_o = (phase_q == PH_FINISH);

  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> phase_q == $past(phase_q) + 1'b1); // R1

endmodule

// File: rtl/sseq_regen.sv
module sseq_regen #(
  parameter int unsigned AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          advance_i,
  input  logic          access_sel_i,
  output logic [AW-1:0] row_o
);

  localparam logic [AW-1:0] LAST_ROW = {AW{1'b1}};

  logic [AW-1:0] row_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                 row_q <= '0;
    else if (advance_i) begin
      if (row_q == LAST_ROW)    row_q <= '0;
      else                      row_q <= row_q + 1'b1;
    end
  end

  assign row_o = row_q;

  AST_ROW_FROZEN_ON_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    access_sel_i |=> $stable(row_q)); // R9

endmodule

// File: rtl/sseq_access.sv
module sseq_access
  import sseq_pkg::*;
#(
  parameter int unsigned AW = 10,
  parameter int unsigned DW = 36
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          at_select_i,
  input  logic          at_finish_i,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_write_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  output sseq_mode_e    mode_o,
  output logic [AW-1:0] sar_o,
  output logic [DW-1:0] wdata_o,
  output logic          done_o,
  output logic          resume_o
);

  logic          pend_q;
  logic          wr_q;
  logic [AW-1:0] sar_q;
  logic [DW-1:0] wd_q;
  sseq_mode_e    mode_q;
  sseq_mode_e    mode_cur;
  logic          resume_q;
  logic          take;

  assign take = req_valid_i && !pend_q;

  always_comb begin
    if (at_select_i) begin
      if (!pend_q)    mode_cur = MODE_REGEN;
      else if (wr_q)  mode_cur = MODE_WRITE;
      else            mode_cur = MODE_READ;
    end else begin
      mode_cur = mode_q;
    end
  end

  assign done_o = at_finish_i && (mode_cur != MODE_REGEN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q   <= 1'b0;
      wr_q     <= 1'b0;
      sar_q    <= '0;
      wd_q     <= '0;
      mode_q   <= MODE_REGEN;
      resume_q <= 1'b0;
    end else begin
      resume_q <= done_o;
      if (at_select_i) mode_q <= mode_cur;
      if (take) begin
        pend_q <= 1'b1;
        wr_q   <= req_write_i;
        sar_q  <= req_addr_i;
        wd_q   <= req_wdata_i;
      end else if (done_o) begin
        pend_q <= 1'b0;
        sar_q  <= '0;
      end
    end
  end

  assign req_ready_o = !pend_q;
  assign mode_o      = mode_cur;
  assign sar_o       = sar_q;
  assign wdata_o     = wd_q;
  assign resume_o    = resume_q;

  AST_RESUME_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    resume_q |=> !resume_q); // R7
  AST_BUSY_HOLDS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !done_o) |=> $stable(sar_q) && $stable(wd_q) && pend_q); // R4
  AST_SAR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> sar_q == '0 && resume_q); // R7
  AST_RESUME_AT_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    resume_q |-> at_select_i); // R3

endmodule

// File: rtl/sseq_array.sv
module sseq_array
  import sseq_pkg::*;
#(
  parameter int unsigned AW = 10,
  parameter int unsigned DW = 36
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          at_select_i,
  input  logic          at_sample_i,
  input  logic          at_finish_i,
  input  sseq_mode_e    mode_i,
  input  logic [AW-1:0] regen_row_i,
  input  logic [AW-1:0] sar_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rd_data_o
);

  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] sel_q;
  logic [DW-1:0] smp_q;
  logic [DW-1:0] rd_q;
  logic          is_write;
  logic          is_read;

  assign is_write = (mode_i == MODE_WRITE);
  assign is_read  = (mode_i == MODE_READ);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= '0;
      smp_q <= '0;
      rd_q  <= '0;
    end else begin
      if (at_select_i) sel_q <= (mode_i == MODE_REGEN) ? regen_row_i : sar_i;
      if (at_sample_i && !is_write) smp_q <= mem[sel_q];
      if (at_finish_i && is_read)   rd_q  <= smp_q;
    end
  end

  always_ff @(posedge clk) begin
    if (at_sample_i && is_write)      mem[sel_q] <= wdata_i;
    else if (at_finish_i && !is_write) mem[sel_q] <= smp_q;
  end

  assign rd_data_o = rd_q;

  AST_RDATA_ONLY_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(rd_q) && $past(rst_n)) |-> $past(at_finish_i && is_read)); // R8

endmodule

// File: rtl/storage_refresh_seq.sv
module storage_refresh_seq
  import sseq_pkg::*;
#(
  parameter int unsigned AW = 10,
  parameter int unsigned DW = 36
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic [DW-1:0] rd_data,
  output logic          resume,
  output logic [1:0]    phase,
  output logic [AW-1:0] regen_addr
);

  logic [PHASE_W-1:0] ph;
  logic               at_select;
  logic               at_sample;
  logic               at_finish;
  sseq_mode_e         mode;
  logic [AW-1:0]      sar;
  logic [DW-1:0]      wdata;
  logic [AW-1:0]      row;
  logic               done;
  logic               regen_step;
  logic               access_sel;

  sseq_phase u_phase (
    .clk         (clk),
    .rst_n       (rst_n),
    .phase_o     (ph),
    .at_select_o (at_select),
    .at_sample_o (at_sample),
    .at_finish_o (at_finish)
  );

  sseq_access #(.AW(AW), .DW(DW)) u_access (
    .clk         (clk),
    .rst_n       (rst_n),
    .at_select_i (at_select),
    .at_finish_i (at_finish),
    .req_valid_i (req_valid),
    .req_ready_o (req_ready),
    .req_write_i (req_write),
    .req_addr_i  (req_addr),
    .req_wdata_i (req_wdata),
    .mode_o      (mode),
    .sar_o       (sar),
    .wdata_o     (wdata),
    .done_o      (done),
    .resume_o    (resume)
  );

  assign regen_step = at_select && (mode == MODE_REGEN);
  assign access_sel = at_select && (mode != MODE_REGEN);

  sseq_regen #(.AW(AW)) u_regen (
    .clk          (clk),
    .rst_n        (rst_n),
    .advance_i    (regen_step),
    .access_sel_i (access_sel),
    .row_o        (row)
  );

  sseq_array #(.AW(AW), .DW(DW)) u_array (
    .clk         (clk),
    .rst_n       (rst_n),
    .at_select_i (at_select),
    .at_sample_i (at_sample),
    .at_finish_i (at_finish),
    .mode_i      (mode),
    .regen_row_i (row),
    .sar_i       (sar),
    .wdata_i     (wdata),
    .rd_data_o   (rd_data)
  );

  assign phase      = ph;
  assign regen_addr = row;

  AST_DONE_THEN_REGEN: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (mode == MODE_REGEN)); // R11
  AST_RESUME_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    resume |-> $past(done)); // R3

endmodule

// File: tb/tb_storage_refresh_seq.sv
module tb_storage_refresh_seq;

  localparam int AW = 10;
  localparam int DW = 36;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [DW-1:0] rd_data;
  logic          resume;
  logic [1:0]    phase;
  logic [AW-1:0] regen_addr;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  logic [DW-1:0] model [1024];
  logic          known [1024];
  logic [DW-1:0] last_rd = '0;

  always #5 clk = ~clk;

  storage_refresh_seq #(.AW(AW), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_data(rd_data), .resume(resume), .phase(phase), .regen_addr(regen_addr)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_latency(input logic [1:0] p);
    return ((4 - ((p + 1) % 4)) % 4) + 5;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  logic [1:0] prev_ph;
  bit         ph_ok = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (ph_ok) check(phase == prev_ph + 2'd1, "R1 phase step", phase, prev_ph + 2'd1);
      prev_ph = phase;
      ph_ok = 1;
    end
  end

  task automatic do_op(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d, input bit junk);
    logic [1:0] p;
    logic [AW-1:0] row_start;
    int n;
    int lat;
    @(negedge clk);
    n = 0;
    while (!req_ready && n < 20) begin @(negedge clk); n++; end
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    p = phase;
    lat = exp_latency(p);
    @(posedge clk);
    if (wr) begin model[a] = d; known[a] = 1'b1; end
    n = 0;
    row_start = '0;
    forever begin
      @(negedge clk);
      n++;
      if (n == 1) begin
        req_valid = junk; req_write = 1'b1;
        req_addr = a ^ 10'h001; req_wdata = ~d;
      end
      if (n == lat - 4) row_start = regen_addr;
      if (resume || n > 12) break;
      check(!req_ready, "R4 ready low while busy", req_ready, 0);
    end
    req_valid = 1'b0;
    check(resume, "R3 resume seen", resume, 1);
    check(n == lat, "R3 latency", n, lat);
    check(phase == 2'd0, "R3 resume at phase 0", phase, 0);
    check(regen_addr == row_start, "R9 counter frozen", regen_addr, row_start);
    if (wr) begin
      check(rd_data == last_rd, "R8 rd_data held over write", rd_data, last_rd);
    end else begin
      check(rd_data == model[a], "R6 read data", rd_data, model[a]);
      last_rd = model[a];
    end
    @(negedge clk);
    check(!resume, "R7 resume single cycle", resume, 0);
    check(regen_addr == row_start + 1'b1, "R11 regen resumes", regen_addr, row_start + 1'b1);
    check(rd_data == last_rd, "R8 rd_data stable", rd_data, last_rd);
  endtask

  initial begin
    logic [AW-1:0] r0;
    void'($urandom(32'd20531));
    for (int i = 0; i < 1024; i++) begin model[i] = '0; known[i] = 1'b0; end
    repeat (3) @(negedge clk);
    check(phase == 2'd0, "R1 reset phase", phase, 0);
    check(regen_addr == '0, "R2 reset counter", regen_addr, 0);
    check(req_ready == 1'b1, "R4 reset ready", req_ready, 1);
    check(resume == 1'b0, "R7 reset resume", resume, 0);
    check(rd_data == '0, "R8 reset rd_data", rd_data, 0);
    rst_n = 1'b1;

    // R2 idle advance over one regeneration cycle
    @(negedge clk);
    while (phase != 2'd1) @(negedge clk);
    r0 = regen_addr;
    repeat (4) @(negedge clk);
    check(regen_addr == r0 + 1'b1, "R2 advance per cycle", regen_addr, r0 + 1'b1);

    // directed: write then read back at all-zero and all-one addresses (R5, R6)
    do_op(1'b1, 10'h000, 36'hF_0F0F_0F0F, 1'b0);
    do_op(1'b1, 10'h3FF, 36'h1_2345_6789, 1'b1);
    do_op(1'b0, 10'h000, '0, 1'b0);
    do_op(1'b0, 10'h3FF, '0, 1'b1);
    do_op(1'b0, 10'h3FF, '0, 1'b0);

    // random mix over a small address set, random gaps to vary phase (R3, R4, R5, R6)
    for (int k = 0; k < 300; k++) begin
      logic [AW-1:0] a;
      bit wr;
      a  = AW'($urandom_range(0, 15)) + 10'h100;
      wr = (!known[a]) || ($urandom_range(0, 1) == 1);
      do_op(wr, a, {$urandom(), 4'($urandom())}, $urandom_range(0, 1) == 1);
      repeat ($urandom_range(0, 6)) @(negedge clk);
    end

    // R2 wrap and R10 retention over a full sweep
    while (!(regen_addr == 10'h3FF && phase == 2'd1)) @(negedge clk);
    repeat (4) @(negedge clk);
    check(regen_addr == '0, "R2 wrap to zero", regen_addr, 0);
    repeat (4200) @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      if (known[10'h100 + i]) do_op(1'b0, AW'(10'h100 + i), '0, 1'b0);
    end
    do_op(1'b0, 10'h000, '0, 1'b0);
    check(rd_data == 36'hF_0F0F_0F0F, "R10 retention", rd_data, 36'hF_0F0F_0F0F);

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule